// File: doc/BRIEF.md
# Boot Shadow Memory Decoder

This block produces the chip selects for a microcontroller that has a 64K program space and a separate 64K data space. Program fetches are marked by an active-low fetch strobe. Data reads and writes are marked by active-low read and write strobes. From these and the 16-bit address, the block drives active-low selects for a boot ROM, a program RAM and a data RAM. It also drives a shared output enable, a shared write enable, and eight active-low I/O strobes that cover the top eight data addresses.

After reset the map is in boot mode. Fetches go to the boot ROM, and data accesses go to the program RAM, so firmware can copy the ROM image into RAM, one address at a time. When firmware finishes the copy, it accesses the highest I/O address. On the trailing (rising) edge of that strobe, a sticky shadow bit is set. From then on, fetches are served by the program RAM, the ROM is never selected again, and the data RAM takes over data space. Only reset clears the bit.

The select outputs are purely combinational from the address, the strobes and the shadow bit, which keeps decode delay short. The shadow bit is captured on an internal clock after a short synchronizer, and it is visible on an output.

Top module: `boot_shadow_decoder`

## Requirements
- R1: With the shadow bit clear, a fetch (`fetch_n` low) at any address, including 0xFFF8..0xFFFF, drives `rom_cs_n` low, `oe_n` low and `we_n` high. `pram_cs_n` and `dram_cs_n` stay high.
- R2: With the shadow bit clear, a data access below 0xFFF8 drives `pram_cs_n` low. `oe_n` is low when `rd_n` is low, and `we_n` is low when `wr_n` is low.
- R3: A data access at 0xFFF8+n (n = 0..7) drives only `io_n[n]` low, where n is address bits 2..0. No memory select is asserted. `oe_n` and `we_n` follow `rd_n` and `wr_n`.
- R4: During a fetch the I/O window is ignored: all `io_n` bits stay high and program memory is selected.
- R5: When `fetch_n`, `rd_n` and `wr_n` are all high, every select, enable and I/O strobe is high.
- R6: When `fetch_n` is low together with `rd_n` or `wr_n`, the fetch decode wins: there is no data select, no I/O strobe, and `we_n` is high.
- R7: `shadow_on` does not set while `io_n[7]` is held low. It sets on the third rising clock edge after `io_n[7]` returns high (SYNC_STAGES+1 edges).
- R8: With the shadow bit set, a fetch drives `pram_cs_n` low, and a data access below 0xFFF8 drives `dram_cs_n` low. `rom_cs_n` stays high.
- R9: Once set, `shadow_on` stays set through further accesses to 0xFFFF. Asserting `rst_n` low clears it at once, without waiting for a clock.
- R10: Pulses on `io_n[0]`..`io_n[6]` leave `shadow_on` clear.
- R11: After reset, `shadow_on` is low and the map is in boot mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the trigger strobe |
| rst_n | input | 1 | Asynchronous active-low reset; clears the shadow bit |
| addr | input | 16 | Address bus |
| fetch_n | input | 1 | Active-low program fetch strobe |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low data write strobe |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| pram_cs_n | output | 1 | Program RAM select, active low |
| dram_cs_n | output | 1 | Data RAM select, active low |
| oe_n | output | 1 | Memory output enable, active low |
| we_n | output | 1 | Memory write enable, active low |
| io_n | output | 8 | I/O strobes for 0xFFF8..0xFFFF, active low |
| shadow_on | output | 1 | Shadow bit, high once program RAM serves fetches |

## Verification
The bench builds the decoder with its default parameters: a 16-bit address, a 3-bit I/O select and two synchronizer stages. This yields an eight-strobe window at 0xFFF8..0xFFFF and a trigger latency of exactly three clock edges, both of which the bench can pin down. The 16-bit width puts the window edges (0xFFF7 against 0xFFF8) and the top trigger address within reach of literal vectors. The two-stage synchronizer lets the bench separate "strobe still low" from "strobe just released" by edge count.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_FETCH = 2'd1,
      ACC_DATA  = 2'd2
   } acc_kind_e;

   typedef struct packed {
      logic rom;
      logic pram;
      logic dram;
   } mem_sel_t;

   // fetch outranks data strobes
   function automatic acc_kind_e classify(input logic fetch_n,
                                          input logic rd_n,
                                          input logic wr_n);
      if (!fetch_n)
         return ACC_FETCH;
      else if (!rd_n || !wr_n)
         return ACC_DATA;
      else
         return ACC_IDLE;
   endfunction

endpackage

// File: rtl/shadow_io_window.sv
module shadow_io_window
   import shadow_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SEL_W  = 3,
   localparam int IO_COUNT = 1 << SEL_W
) (
   input  logic [ADDR_W-1:0]   addr,
   input  acc_kind_e           kind,
   output logic                in_window,
   output logic [IO_COUNT-1:0] io_n
);

   logic [SEL_W-1:0] sel;
   logic             strobe_ok;

   initial begin : param_chk
      assert (ADDR_W > SEL_W)
         else $error("address must be wider than the I/O select");
   end

   // wide AND over the upper address bits
   assign in_window = &addr[ADDR_W-1:SEL_W];
   assign sel       = addr[SEL_W-1:0];
   assign strobe_ok = (kind == ACC_DATA) && in_window;

   generate
      for (genvar gi = 0; gi < IO_COUNT; gi++) begin : g_strobe
         assign io_n[gi] = !(strobe_ok && (sel == SEL_W'(gi)));
      end
   endgenerate

endmodule

// File: rtl/shadow_mem_select.sv
module shadow_mem_select
   import shadow_pkg::*;
(
   input  acc_kind_e kind,
   input  logic      in_window,
   input  logic      shadow,
   input  logic      rd_n,
   input  logic      wr_n,
   output mem_sel_t  sel,
   output logic      oe_n,
   output logic      we_n
);

   always_comb begin
      sel = '0;
      unique case (kind)
         ACC_FETCH: begin
            if (shadow) sel.pram = 1'b1;
            else        sel.rom  = 1'b1;
         end
         ACC_DATA: begin
            if (!in_window) begin
               if (shadow) sel.dram = 1'b1;
               else        sel.pram = 1'b1;
            end
         end
         default: sel = '0;
      endcase
   end

   assign oe_n = !((kind == ACC_FETCH) || ((kind == ACC_DATA) && !rd_n));
   assign we_n = !((kind == ACC_DATA) && !wr_n);

endmodule

// File: rtl/shadow_mode_latch.sv
module shadow_mode_latch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_n,
   output logic mode
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   level;
   logic                   last_q;

   initial begin : param_chk
      assert (SYNC_STAGES >= 1)
         else $error("at least one synchronizer stage is needed");
   end

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= trig_n;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_n};
         end
      end
   endgenerate

   assign level = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= 1'b1;
         mode   <= 1'b0;
      end else begin
         last_q <= level;
         if (level && !last_q)
            mode <= 1'b1;
      end
   end

   // R9
   mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode |=> mode);

endmodule

// File: rtl/boot_shadow_decoder.sv
module boot_shadow_decoder
   import shadow_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int IO_COUNT   = 1 << SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                fetch_n,
   input  logic                rd_n,
   input  logic                wr_n,
   output logic                rom_cs_n,
   output logic                pram_cs_n,
   output logic                dram_cs_n,
   output logic                oe_n,
   output logic                we_n,
   output logic [IO_COUNT-1:0] io_n,
   output logic                shadow_on
);

   acc_kind_e kind;
   logic      in_window;
   mem_sel_t  sel;

   assign kind = classify(fetch_n, rd_n, wr_n);

   shadow_io_window #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_window (
      .addr      (addr),
      .kind      (kind),
      .in_window (in_window),
      .io_n      (io_n)
   );

   shadow_mem_select u_select (
      .kind      (kind),
      .in_window (in_window),
      .shadow    (shadow_on),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .sel       (sel),
      .oe_n      (oe_n),
      .we_n      (we_n)
   );

   shadow_mode_latch #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_n (io_n[IO_COUNT-1]),
      .mode   (shadow_on)
   );

   assign rom_cs_n  = !sel.rom;
   assign pram_cs_n = !sel.pram;
   assign dram_cs_n = !sel.dram;

   // R3
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rom_cs_n, pram_cs_n, dram_cs_n}) >= 2);

   // R3
   io_excludes_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_n != '1) |-> (rom_cs_n && pram_cs_n && dram_cs_n && $onehot0(~io_n)));

   // R4
   fetch_no_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_n |-> (io_n == '1));

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_n && rd_n && wr_n) |->
         (rom_cs_n && pram_cs_n && dram_cs_n && oe_n && we_n && io_n == '1));

   // R8
   rom_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_on |-> rom_cs_n);

endmodule

// File: tb/boot_shadow_decoder_bench.sv
module boot_shadow_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        fetch_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        rom_cs_n, pram_cs_n, dram_cs_n, oe_n, we_n, shadow_on;
   logic [7:0]  io_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = !clk;

   boot_shadow_decoder u_boot_shadow_decoder (
      .clk(clk), .rst_n(rst_n), .addr(addr), .fetch_n(fetch_n), .rd_n(rd_n),
      .wr_n(wr_n), .rom_cs_n(rom_cs_n), .pram_cs_n(pram_cs_n),
      .dram_cs_n(dram_cs_n), .oe_n(oe_n), .we_n(we_n), .io_n(io_n),
      .shadow_on(shadow_on)
   );

   // {addr, fetch_n rd_n wr_n, rom pram dram oe we, io}
   localparam logic [31:0] VEC [10] = '{
      {16'h0000, 3'b011, 5'b01101, 8'hFF},  // R1
      {16'hFFFF, 3'b011, 5'b01101, 8'hFF},  // R1 R4
      {16'h1234, 3'b101, 5'b10101, 8'hFF},  // R2
      {16'hFFF7, 3'b110, 5'b10110, 8'hFF},  // R2
      {16'hFFF8, 3'b101, 5'b11101, 8'hFE},  // R3
      {16'hFFFB, 3'b110, 5'b11110, 8'hF7},  // R3
      {16'hFFFE, 3'b101, 5'b11101, 8'hBF},  // R3
      {16'hFFFF, 3'b111, 5'b11111, 8'hFF},  // R5
      {16'hFFFA, 3'b001, 5'b01101, 8'hFF},  // R6
      {16'h0100, 3'b010, 5'b01101, 8'hFF}   // R6
   };
   localparam string VTAG [10] = '{"R1", "R4", "R2", "R2", "R3", "R3", "R3",
                                   "R5", "R6", "R6"};

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [2:0] s);
      @(negedge clk);
      addr = a;
      {fetch_n, rd_n, wr_n} = s;
      #1;
   endtask

   function automatic logic [12:0] outs();
      return {rom_cs_n, pram_cs_n, dram_cs_n, oe_n, we_n, io_n};
   endfunction

   task automatic idle();
      @(negedge clk);
      {fetch_n, rd_n, wr_n} = 3'b111;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11
      check("R11", 32'(shadow_on), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      apply(16'h0000, 3'b011);
      check("R11", 32'(outs()), 32'(13'b0110111111111));
      idle();

      for (int i = 0; i < 10; i++) begin
         apply(VEC[i][31:16], VEC[i][15:13]);
         check(VTAG[i], 32'(outs()), 32'(VEC[i][12:0]));
         idle();
      end
      repeat (4) @(posedge clk);
      #1;
      // R10: lower strobes leave the shadow bit clear
      check("R10", 32'(shadow_on), 32'd0);

      // R7: hold the trigger strobe low
      apply(16'hFFFF, 3'b110);
      check("R3", 32'(io_n), 32'h7F);
      repeat (3) @(posedge clk);
      #1;
      check("R7", 32'(shadow_on), 32'd0);
      @(negedge clk);
      wr_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check("R7", 32'(shadow_on), 32'd0);
      @(posedge clk);
      #1;
      check("R7", 32'(shadow_on), 32'd1);

      // R8
      apply(16'h0000, 3'b011);
      check("R8", 32'(outs()), 32'(13'b1010111111111));
      apply(16'hFFFF, 3'b011);
      check("R8", 32'(outs()), 32'(13'b1010111111111));
      apply(16'h1234, 3'b101);
      check("R8", 32'(outs()), 32'(13'b1100111111111));
      apply(16'h4000, 3'b110);
      check("R8", 32'(outs()), 32'(13'b1101011111111));
      idle();

      // R9: a second trigger pulse keeps the bit set
      apply(16'hFFFF, 3'b101);
      idle();
      repeat (5) @(posedge clk);
      #1;
      check("R9", 32'(shadow_on), 32'd1);

      // R9: asynchronous clear between edges
      @(negedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      check("R9", 32'(shadow_on), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      apply(16'h0000, 3'b011);
      check("R11", 32'(outs()), 32'(13'b0110111111111));
      idle();
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule